// File: doc/BRIEF.md
# Quorum-Locked Four-Line Redundant Clock

This block produces four clock lines that stay in lockstep without any local oscillator. Four identical elements each own one line and all of them see all four lines. An element changes its own line only after the lines reach agreement: when at least three of the four lines are high, every element schedules a fall. When fewer than two are high, every element schedules a rise. Each scheduled edge lands after a fixed count of sampling-clock cycles, held in each element's own down-counter. The block runs entirely inside a fast sampling clock, and the four lines are registered outputs of that clock.

Because the rise and fall decisions depend on agreement between lines, one element that is stuck low, stuck high, or babbling random values cannot move the quorum. The three healthy elements keep oscillating with unchanged timing. A set-to-agree path pulls a lagging element back into step. If the two-of-four quorum rises while an element is low and has no rise pending, that element goes high on the next cycle. The fall works the same way. A start input keeps every line low until it is seen for the first time, and then launches all elements together. A per-element fault-injection field allows the tolerance to be exercised.

Top module: `quorum_clock`

## Requirements
- R1: While reset is asserted, and on the first sample after it, all four lines are 0.
- R2: While no start has yet been seen and no fault is injected, all four lines stay 0, however long the wait.
- R3: If start is first sampled high at clock edge S, every healthy line rises at edge S+DELAY, where DELAY is the delay parameter (default 8).
- R4: After the first rise, every healthy line is high for exactly DELAY+1 sampling cycles, then low for exactly DELAY+1 cycles, and so on. All healthy lines are equal on every cycle.
- R5: Bits [2i+1:2i] of fault_sel control line i. Code 0 means normal operation. Code 1 forces the line to 0, code 2 forces it to 1, and code 3 drives it with a pseudo-random bit. A forced value appears on the sample after the edge that sees the code.
- R6: With a single line forced low, the other three keep the timing of R4 exactly.
- R7: With a single line forced high, the other three keep the timing of R4 exactly.
- R8: With a single line driven pseudo-randomly, the other three keep the timing of R4 exactly.
- R9: Consider an element released from a forced-low fault during a low phase. It has no rise pending, so it rises through the set-to-agree path one cycle after the healthy lines rise. It then follows them exactly.
- R10: Consider an element released from a forced-high fault during a high phase. It has no fall pending, so it falls one cycle after the healthy lines fall. It then follows them exactly.
- R11: Dropping start after it has been seen has no effect on the oscillation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches oscillation on its first sampled high |
| fault_sel | input | 8 | Two-bit fault code per element: 0 none, 1 force 0, 2 force 1, 3 pseudo-random |
| clk_line | output | 4 | The four redundant clock lines |

## Verification
The assertions check four properties on every cycle:
- the lines stay low before start;
- a forced code reaches its line one cycle later;
- with at most one faulty element, the lines never split two against two;
- every run of the quorum value lasts exactly DELAY+1 cycles.

Other behaviours can be shown only by the bench's scenarios:
- the exact cycle of the first rise;
- that the healthy lines stay equal under each fault type;
- the one-cycle catch-up of a released element through the set-to-agree path;
- that dropping start has no effect.

// File: rtl/quorum_clock.sv
module quorum_clock #(
  parameter int DELAY = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] fault_sel,
  output logic [3:0] clk_line
);
  localparam int CW = $clog2(DELAY + 1);

  logic [3:0]  own;
  logic [15:0] lfsr;
  logic        started_q;
  logic        q2, q3, q2_q, q3_q;
  logic        rise2, fall2, rise3, fall3;

  assign q2 = (own[0] & own[1]) | (own[0] & own[2]) | (own[0] & own[3])
            | (own[1] & own[2]) | (own[1] & own[3]) | (own[2] & own[3]);
  assign q3 = (own[0] & own[1] & own[2]) | (own[0] & own[1] & own[3])
            | (own[0] & own[2] & own[3]) | (own[1] & own[2] & own[3]);

  assign rise2 = q2 & ~q2_q;
  assign fall2 = ~q2 & q2_q;
  assign rise3 = q3 & ~q3_q;
  assign fall3 = ~q3 & q3_q;

  assign clk_line = own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= SEED;
      started_q <= 1'b0;
      q2_q      <= 1'b0;
      q3_q      <= 1'b0;
    end else begin
      lfsr      <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      started_q <= started_q | start;
      q2_q      <= q2;
      q3_q      <= q3;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_elem
    logic [1:0]    code;
    logic          rnd;
    logic          o;
    logic          tgt;
    logic [CW-1:0] cnt;
    logic          pend_up, pend_dn;

    assign code    = fault_sel[2*i +: 2];
    assign rnd     = lfsr[i] ^ lfsr[i+4] ^ lfsr[i+8] ^ lfsr[i+12];
    assign pend_up = (cnt != '0) & tgt;
    assign pend_dn = (cnt != '0) & ~tgt;
    assign own[i]  = o;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o   <= 1'b0;
        tgt <= 1'b0;
        cnt <= '0;
      end else if (code != 2'd0) begin
        o   <= (code == 2'd3) ? rnd : code[1];
        cnt <= '0;
      end else if (!started_q) begin
        o <= 1'b0;
        if (start) begin
          cnt <= CW'(DELAY);
          tgt <= 1'b1;
        end
      end else begin
        if (cnt == CW'(1)) o <= tgt;
        if (cnt != '0) cnt <= cnt - CW'(1);
        if (rise3) begin
          cnt <= CW'(DELAY);
          tgt <= 1'b0;
        end else if (fall2) begin
          cnt <= CW'(DELAY);
          tgt <= 1'b1;
        end
        if (rise2 && !o && !pend_up) o <= 1'b1;
        if (fall3 && o && !pend_dn) o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/quorum_clock_chk.sv
module quorum_clock_chk #(
  parameter int DELAY = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] fault_sel,
  input logic [3:0] clk_line,
  input logic       started_q
);
  logic [3:0] act;
  logic       m, m_q, seen;
  int         run;

  for (genvar i = 0; i < 4; i++) begin : g_act
    assign act[i] = |fault_sel[2*i +: 2];

    assert_force_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_sel[2*i +: 2] == 2'd1) |=> !clk_line[i]);

    assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_sel[2*i +: 2] == 2'd2) |=> clk_line[i]);
  end

  assign m = $countones(clk_line) >= 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q  <= 1'b0;
      seen <= 1'b0;
      run  <= 0;
    end else begin
      m_q <= m;
      run <= (m != m_q) ? 1 : run + 1;
      if (m && !m_q) seen <= 1'b1;
    end
  end

  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!started_q && fault_sel == 8'd0) |=> (clk_line == 4'd0));

  // single faulty element of any kind: R6, R7 and R8
  assert_no_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(act) && $past($onehot0(act))) |-> ($countones(clk_line) != 2));

  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m != m_q && seen && $onehot0(act)) |-> (run == DELAY + 1));
endmodule

bind quorum_clock quorum_clock_chk #(.DELAY(DELAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fault_sel (fault_sel),
  .clk_line  (clk_line),
  .started_q (started_q)
);

// File: tb/sim_quorum_clock.sv
module sim_quorum_clock;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE     = 3;
  localparam int D          = 8;
  localparam int HALF       = D + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] fault_sel = 8'd0;
  logic [3:0] line;

  int    checks = 0;
  int    failures = 0;
  int    since = -1;
  logic [3:0] skip = 4'd0;
  string tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  quorum_clock #(.DELAY(D)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fault_sel (fault_sel),
    .clk_line  (line)
  );

  always @(posedge clk) begin
    if (!rst_n)          since <= -1;
    else if (since >= 0) since <= since + 1;
    else if (start)      since <= 0;
  end

  function automatic int expv(int s);
    if (s < D) return 0;
    return (((s - D) / HALF) % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string phase_tag();
    if (since < 0)  return "R2";
    if (since <= D) return "R3";
    return tag;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at since=%0d", req, act, exp, since);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(SAMPLE);
    for (int i = 0; i < 4; i++)
      if (!skip[i]) check(phase_tag(), int'(line[i]), expv(since));
  endtask

  task automatic wait_edge(int v);
    do tick(); while (!(expv(since) == v && expv(since - 1) != v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int saw0;
    int saw1;
    saw0 = 0;
    saw1 = 0;
    repeat (3) @(posedge clk);
    #(SAMPLE);
    check("R1", int'(line), 0);
    rst_n = 1'b1;
    tick();
    check("R1", int'(line), 0);
    repeat (20) tick();

    // pre-start forced-high on element 0
    fault_sel[1:0] = 2'd2;
    skip[0] = 1'b1;
    tick();
    check("R5", int'(line[0]), 1);
    repeat (10) tick();
    fault_sel[1:0] = 2'd0;
    tick();
    tick();
    check("R2", int'(line[0]), 0);
    skip[0] = 1'b0;
    repeat (5) tick();

    start = 1'b1;
    tag = "R4";
    repeat (12 * HALF) tick();

    start = 1'b0;
    tag = "R11";
    repeat (8 * HALF) tick();

    // stuck low on element 1, then catch-up on release
    tag = "R6";
    fault_sel[3:2] = 2'd1;
    skip[1] = 1'b1;
    tick();
    check("R5", int'(line[1]), 0);
    repeat (8 * HALF) begin
      tick();
      check("R5", int'(line[1]), 0);
    end
    wait_edge(0);
    tick();
    fault_sel[3:2] = 2'd0;
    tag = "R9";
    wait_edge(1);
    check("R9", int'(line[1]), 0);
    tick();
    check("R9", int'(line[1]), 1);
    skip[1] = 1'b0;
    repeat (4 * HALF) tick();

    // stuck high on element 2, then catch-up on release
    tag = "R7";
    fault_sel[5:4] = 2'd2;
    skip[2] = 1'b1;
    tick();
    check("R5", int'(line[2]), 1);
    repeat (8 * HALF) begin
      tick();
      check("R5", int'(line[2]), 1);
    end
    wait_edge(1);
    tick();
    fault_sel[5:4] = 2'd0;
    tag = "R10";
    wait_edge(0);
    check("R10", int'(line[2]), 1);
    tick();
    check("R10", int'(line[2]), 0);
    skip[2] = 1'b0;
    repeat (4 * HALF) tick();

    // pseudo-random babbling on element 3
    tag = "R8";
    fault_sel[7:6] = 2'd3;
    skip[3] = 1'b1;
    repeat (10 * HALF) begin
      tick();
      if (line[3]) saw1++; else saw0++;
    end
    check("R5", (saw0 > 0 && saw1 > 0) ? 1 : 0, 1);
    fault_sel[7:6] = 2'd0;
    repeat (5 * HALF) tick();
    skip[3] = 1'b0;
    tag = "R4";
    repeat (6 * HALF) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule